// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Controller

This block connects a simple host bus to one SPI flash device on a single chip select, using single-bit SPI mode 0. The host sees three control registers and a flash data window. Each access either selects the registers or the window, and the block holds its ready output low until the work behind the access is finished.

The block has two ways of working. In user mode, software drives the chip select by hand through a stop bit and moves raw bytes. A window write shifts bytes out, and a window read shifts bytes in. A session can span any number of accesses. In the direct modes, every window access runs a complete flash cycle without software help: opcode, address, and either four data bytes out (program) or four data bytes in (read). The opcode comes from a register field. Fast read adds one dummy byte. The address width is 24 or 32 bits, chosen by a register bit.

The serial clock is the system clock divided by the parameter `DIV` (default 4). It idles low. Data changes on its falling edge and is sampled on its rising edge.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset the chip select is high, the serial clock is low, ready is low, and the registers read: offset 0x00 = 0, offset 0x04 = 0, offset 0x10 = 0x00030004 (read mode, stop bit set, opcode 0x03).
- R2: Register accesses decode bus_addr[4:2]. Offset 0x00 bit 16 is the window write enable. Offset 0x04 bit 0 selects 32-bit direct addressing. Offset 0x10 holds the mode in bits [1:0] (0 read, 1 fast read, 2 program, 3 user), the stop bit in bit 2 and the opcode in bits [23:16]. Every other bit, and every other offset, reads 0.
- R3: In user mode the chip select is low exactly while the stop bit is 0, and it stays low across window accesses. Outside user mode it is low only during a direct cycle.
- R4: A user-mode byte write sends bus_wdata[7:0]. A user-mode word write sends lanes [7:0], [15:8], [23:16], [31:24] in that order. Every byte goes out most significant bit first.
- R5: A user-mode byte read returns the 8 received bits in bus_rdata[7:0] with the upper bits 0. A word read puts the first received byte in [7:0] and the fourth in [31:24].
- R6: In mode 2 a window word write sends the opcode, then the address, then the data lanes in the order of R4, all in one chip-select period. Chip select is high when ready is given.
- R7: In mode 0 a window read sends the opcode and the address, then receives 32 bits and returns them in the lane order of R5.
- R8: In mode 1 a window read puts 8 dummy clocks (MOSI 0) between the address and the 32 data bits.
- R9: Window writes are dropped, with no serial clock activity, when the write enable is 0, or when the mode is 0 or 1. Ready is still given.
- R10: The serial clock period is DIV system clocks. It is low whenever chip select is high, and MOSI does not change while it is high.
- R11: Ready is a one-cycle pulse. It comes 1 cycle after a register access is accepted, and N*DIV+1 cycles after acceptance for a window access that shifts N bits.
- R12: With offset 0x04 bit 0 set, direct cycles send all 32 address bits. With it clear, they send only bus_addr[23:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Access request, held until ready |
| bus_win | input | 1 | 1 selects the flash window, 0 the registers |
| bus_we | input | 1 | 1 for write |
| bus_size | input | 1 | 1 for 32-bit access, 0 for byte (user mode only) |
| bus_addr | input | 32 | Register offset or window offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ready |
| bus_ready | output | 1 | Access complete |
| spi_clk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench targets three corner cases. In 24-bit mode it sets random high address bytes, so a design that leaks bus_addr[31:24] onto the wire fails the check. Fast reads are checked for the dummy byte: a design that skips it returns data shifted by one byte. User sessions mix byte and word accesses under one chip select, so a wrong lane order or a session that drops chip select between accesses is caught. Writes made with the enable clear, or in the read modes, must produce no clock edge at all. Serial clock timing and MOSI stability are watched on every clock.

// File: rtl/spi_flash_ctl.sv
module spi_flash_ctl #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_win,
  input  logic        bus_we,
  input  logic        bus_size,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic        spi_clk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int HALF = DIV / 2;
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  typedef enum logic [1:0] {IDLE, SHIFT, DONE} st_t;
  st_t st;

  logic        wen_q, a32_q, stop_q, sclk_q;
  logic [1:0]  mode_q;
  logic [7:0]  op_q;
  logic [79:0] tx_q, seq;
  logic [31:0] rx_q, rdata_q, reg_rd;
  logic [6:0]  nbits_q, slen;
  logic [CW-1:0] div_q;

  wire user = (mode_q == 2'd3);
  wire [31:0] wsw = {bus_wdata[7:0], bus_wdata[15:8], bus_wdata[23:16], bus_wdata[31:24]};
  wire [31:0] rsw = {rx_q[7:0], rx_q[15:8], rx_q[23:16], rx_q[31:24]};
  wire drop = bus_we && (!wen_q || (!user && mode_q != 2'd2));

  always_comb begin
    reg_rd = '0;
    case (bus_addr[4:2])
      3'd0: reg_rd[16] = wen_q;
      3'd1: reg_rd[0] = a32_q;
      3'd4: reg_rd = {8'h00, op_q, 13'h0, stop_q, mode_q};
      default: ;
    endcase
  end

  always_comb begin
    seq = '0;
    if (user) begin
      slen = bus_size ? 7'd32 : 7'd8;
      if (bus_we) seq = bus_size ? {wsw, 48'h0} : {bus_wdata[7:0], 72'h0};
    end else begin
      if (a32_q) seq = {op_q, bus_addr, bus_we ? wsw : 32'h0, 8'h0};
      else       seq = {op_q, bus_addr[23:0], bus_we ? wsw : 32'h0, 16'h0};
      slen = (a32_q ? 7'd72 : 7'd64) + ((!bus_we && mode_q == 2'd1) ? 7'd8 : 7'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; wen_q <= 1'b0; a32_q <= 1'b0; mode_q <= 2'd0; stop_q <= 1'b1;
      op_q <= 8'h03; tx_q <= '0; rx_q <= '0; rdata_q <= '0; nbits_q <= '0;
      div_q <= '0; sclk_q <= 1'b0;
    end else begin
      case (st)
        IDLE: if (bus_req) begin
          if (!bus_win) begin
            rdata_q <= reg_rd;
            st <= DONE;
            if (bus_we) begin
              case (bus_addr[4:2])
                3'd0: wen_q <= bus_wdata[16];
                3'd1: a32_q <= bus_wdata[0];
                3'd4: begin
                  mode_q <= bus_wdata[1:0];
                  stop_q <= bus_wdata[2];
                  op_q   <= bus_wdata[23:16];
                end
                default: ;
              endcase
            end
          end else if (drop) begin
            st <= DONE;
          end else begin
            tx_q <= seq;
            nbits_q <= slen;
            div_q <= '0;
            st <= SHIFT;
          end
        end
        SHIFT: begin
          div_q <= div_q + 1'b1;
          if (div_q == CW'(HALF - 1)) begin
            sclk_q <= 1'b1;
            rx_q <= {rx_q[30:0], spi_miso};
          end
          if (div_q == CW'(DIV - 1)) begin
            sclk_q <= 1'b0;
            div_q <= '0;
            tx_q <= {tx_q[78:0], 1'b0};
            nbits_q <= nbits_q - 1'b1;
            if (nbits_q == 7'd1) begin
              st <= DONE;
              rdata_q <= (user && !bus_size) ? {24'h0, rx_q[7:0]} : rsw;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign bus_ready = (st == DONE);
  assign bus_rdata = rdata_q;
  assign spi_clk   = sclk_q;
  assign spi_mosi  = (st == SHIFT) && tx_q[79];
  assign spi_cs_n  = user ? stop_q : (st != SHIFT);

  a_r10_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_clk);
  a_r10_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_clk && $past(spi_clk)) |-> $stable(spi_mosi));
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
  a_r11_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && bus_req && !bus_win) |=> bus_ready);
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && bus_req && bus_win && drop) |=> (bus_ready && !spi_clk));
endmodule

// File: tb/sim_spi_flash_ctl.sv
module sim_spi_flash_ctl;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic bus_req = 0, bus_win = 0, bus_we = 0, bus_size = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_ready, spi_clk, spi_cs_n, spi_mosi, spi_miso;

  spi_flash_ctl #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .spi_clk(spi_clk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso));

  int vec = 0, bad = 0, cyc = 0;
  logic [127:0] resp = '0, cap;
  int ncap;
  logic mon_clr = 1'b0;

  assign spi_miso = (ncap < 128) ? resp[127 - ncap] : 1'b0;

  always @(posedge spi_clk or posedge mon_clr)
    if (mon_clr) begin cap <= '0; ncap <= 0; end
    else if (!spi_cs_n) begin cap <= {cap[126:0], spi_mosi}; ncap <= ncap + 1; end

  int acc_id = 0, last_id = 0, gap = 0, terr = 0;
  bit seen = 0;
  logic ps = 0, pm = 0;
  always @(negedge clk) begin
    if (acc_id != last_id) begin seen = 0; last_id = acc_id; end
    if (spi_clk && ps && spi_mosi !== pm) terr++;
    if (spi_cs_n && spi_clk) terr++;
    gap++;
    if (spi_clk && !ps) begin
      if (seen && gap != DIV) terr++;
      seen = 1; gap = 0;
    end
    ps = spi_clk; pm = spi_mosi;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    vec++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", r, act, exp); end
  endtask

  task automatic acc(input bit win, input bit we, input bit sz, input logic [31:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output int lat);
    @(negedge clk);
    acc_id++;
    bus_req = 1; bus_win = win; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!bus_ready);
    rd = bus_rdata;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic regw(input logic [31:0] off, input logic [31:0] v);
    logic [31:0] rd; int lat;
    acc(0, 1, 1, off, v, rd, lat);
  endtask

  task automatic regr(input logic [31:0] off, output logic [31:0] rd);
    int lat;
    acc(0, 0, 1, off, 0, rd, lat);
  endtask

  task automatic clr_mon();
    mon_clr = 1; #1; mon_clr = 0;
  endtask

  function automatic logic [31:0] ctlv(input logic [1:0] m, input bit stop, input logic [7:0] op);
    return {8'h00, op, 13'h0, stop, m};
  endfunction

  function automatic logic [31:0] sw32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [31:0] rword(input logic [127:0] r, input int s);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) v[8*k +: 8] = r[127 - s - 8*k -: 8];
    return v;
  endfunction

  function automatic logic [127:0] dseq(input logic [7:0] op, input logic [31:0] a,
                                        input logic [31:0] d, input bit a32, input bit we);
    logic [127:0] v = '0;
    if (a32) v[127:88] = {op, a}; else v[127:96] = {op, a[23:0]};
    if (we) begin
      if (a32) v[87:56] = sw32(d); else v[95:64] = sw32(d);
    end
    return v;
  endfunction

  function automatic logic [127:0] capl();
    return cap << (128 - ncap);
  endfunction

  initial begin
    logic [31:0] rd, a, d;
    logic [7:0] op;
    logic [127:0] ev;
    int lat, pos, w, kind, len, hl;
    bit a32, fast;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_clk === 1'b0 && bus_ready === 1'b0, "R1 pins in reset",
        {spi_cs_n, spi_clk, bus_ready}, 3'b100);
    rst_n = 1;
    regr(32'h00, rd); chk(rd == 0, "R1 cfg reset", rd, 0);
    regr(32'h04, rd); chk(rd == 0, "R1 ce reset", rd, 0);
    regr(32'h10, rd); chk(rd == 32'h0003_0004, "R1 ctl reset", rd, 32'h0003_0004);

    regw(32'h00, 32'hFFFF_FFFF); regr(32'h00, rd); chk(rd == 32'h0001_0000, "R2 cfg bits", rd, 32'h0001_0000);
    regw(32'h04, 32'hFFFF_FFFF); regr(32'h04, rd); chk(rd == 1, "R2 ce bits", rd, 1);
    regw(32'h10, 32'hFFFF_FFFF); regr(32'h10, rd); chk(rd == 32'h00FF_0007, "R2 ctl bits", rd, 32'h00FF_0007);
    regr(32'h08, rd); chk(rd == 0, "R2 unmapped", rd, 0);
    acc(0, 0, 1, 32'h10, 0, rd, lat); chk(lat == 1, "R11 reg latency", lat, 1);

    regw(32'h04, 0);
    regw(32'h00, 0);
    regw(32'h10, ctlv(2'd3, 1'b1, 8'h00));
    chk(spi_cs_n === 1'b1, "R3 user stop=1", spi_cs_n, 1);
    regw(32'h10, ctlv(2'd3, 1'b0, 8'h00));
    chk(spi_cs_n === 1'b0, "R3 user stop=0", spi_cs_n, 0);
    clr_mon();
    acc(1, 1, 1, 0, 32'hA5A5_5A5A, rd, lat);
    chk(ncap == 0 && lat == 1, "R9 write with enable clear", {ncap, lat}, {32'd0, 32'd1});
    regw(32'h00, 32'h0001_0000);

    resp = {$urandom, $urandom, $urandom, $urandom};
    clr_mon();
    acc(1, 1, 0, 0, 32'h0000_009F, rd, lat);
    chk(lat == 8 * DIV + 1, "R11 byte latency", lat, 8 * DIV + 1);
    acc(1, 0, 0, 0, 0, rd, lat); chk(rd == {24'h0, resp[119:112]}, "R5 byte read 1", rd, {24'h0, resp[119:112]});
    acc(1, 0, 0, 0, 0, rd, lat); chk(rd == {24'h0, resp[111:104]}, "R5 byte read 2", rd, {24'h0, resp[111:104]});
    chk(spi_cs_n === 1'b0 && ncap == 24, "R3 session held", {spi_cs_n, ncap}, {1'b0, 32'd24});
    chk(capl() == {8'h9F, 120'h0}, "R4 opcode byte", capl(), {8'h9F, 120'h0});
    regw(32'h10, ctlv(2'd3, 1'b1, 8'h00));
    chk(spi_cs_n === 1'b1, "R3 session closed", spi_cs_n, 1);

    for (int s = 0; s < 10; s++) begin
      resp = {$urandom, $urandom, $urandom, $urandom};
      regw(32'h10, ctlv(2'd3, 1'b0, 8'h00));
      clr_mon();
      ev = '0; pos = 0;
      for (int k = 0; k < 3; k++) begin
        kind = $urandom % 4; d = $urandom;
        case (kind)
          0: begin acc(1, 1, 0, 0, d, rd, lat); ev[127 - pos -: 8] = d[7:0]; w = 8; end
          1: begin acc(1, 1, 1, 0, d, rd, lat); ev[127 - pos -: 32] = sw32(d); w = 32; end
          2: begin acc(1, 0, 0, 0, 0, rd, lat); w = 8;
               chk(rd == {24'h0, resp[127 - pos -: 8]}, "R5 random byte read", rd, {24'h0, resp[127 - pos -: 8]}); end
          default: begin acc(1, 0, 1, 0, 0, rd, lat); w = 32;
               chk(rd == rword(resp, pos), "R5 random word read", rd, rword(resp, pos)); end
        endcase
        chk(lat == w * DIV + 1, "R11 window latency", lat, w * DIV + 1);
        pos += w;
      end
      chk(spi_cs_n === 1'b0, "R3 cs low in session", spi_cs_n, 0);
      regw(32'h10, ctlv(2'd3, 1'b1, 8'h00));
      chk(ncap == pos && capl() == ev, "R4 user stream", capl(), ev);
    end

    for (int t = 0; t < 24; t++) begin
      a = $urandom; d = $urandom; op = 8'($urandom); a32 = $urandom % 2;
      resp = {$urandom, $urandom, $urandom, $urandom};
      regw(32'h04, {31'h0, a32});
      regw(32'h10, ctlv(2'd2, 1'b1, op));
      clr_mon();
      acc(1, 1, 1, a, d, rd, lat);
      len = a32 ? 72 : 64;
      chk(spi_cs_n === 1'b1, "R6 cs high at ready", spi_cs_n, 1);
      chk(lat == len * DIV + 1, "R11 direct write latency", lat, len * DIV + 1);
      chk(ncap == len && capl() == dseq(op, a, d, a32, 1), "R6 R12 direct write stream",
          capl(), dseq(op, a, d, a32, 1));

      a = $urandom; op = 8'($urandom); a32 = $urandom % 2; fast = $urandom % 2;
      resp = {$urandom, $urandom, $urandom, $urandom};
      regw(32'h04, {31'h0, a32});
      regw(32'h10, ctlv(fast ? 2'd1 : 2'd0, 1'b1, op));
      clr_mon();
      acc(1, 0, 1, a, 0, rd, lat);
      hl = (a32 ? 40 : 32) + (fast ? 8 : 0);
      chk(spi_cs_n === 1'b1 && ncap == hl + 32, "R8 read bit count", ncap, hl + 32);
      chk(capl() == dseq(op, a, 0, a32, 0), "R7 R12 read header", capl(), dseq(op, a, 0, a32, 0));
      chk(rd == rword(resp, hl), fast ? "R8 fast read data" : "R7 read data", rd, rword(resp, hl));

      regw(32'h10, ctlv(fast ? 2'd1 : 2'd0, 1'b1, op));
      clr_mon();
      acc(1, 1, 1, a, $urandom, rd, lat);
      chk(ncap == 0 && lat == 1, "R9 write in read mode", ncap, 0);
    end

    chk(terr == 0, "R10 clock period and mosi hold", terr, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule